// File: doc/BRIEF.md
# Wormhole XY Mesh Router

This block is a five-port packet switch for one node of a regular two-dimensional mesh. The ports face the local node and the north, south, east and west neighbours. Every port moves 34-bit flits: a 32-bit payload plus a start-of-packet marker and a last-flit marker. Each input buffers arriving flits in a small FIFO. Each output presents flits to the next hop with a write strobe, and the next hop answers with an accept signal.

The first flit of a packet carries an 8-bit destination made of a 4-bit column and a 4-bit row. The router compares the destination with its own coordinates, which are parameters. It resolves the column first and then the row. The output it picks stays reserved for that input until the last flit of the packet has been taken. When several waiting packets want the same idle output, a rotating priority chooses among them.

Top module: `mesh_xy_router`

## Requirements
- R1: The first cycle after reset shows every out_wr low and every in_wok high.
- R2: Flit bit 33 marks the first flit of a packet and bit 32 marks the last one. Bits 31:0 are payload. In the first flit, bits 3:0 hold the destination column and bits 7:4 hold the destination row. Every flit leaves with all 34 bits unchanged, and the flits of one input reach an output in their arrival order.
- R3: Port indices are 0 local, 1 north, 2 south, 3 east and 4 west. A packet goes east if its column is greater than MY_X and west if it is smaller. If the columns match, it goes north if its row is greater than MY_Y and south if it is smaller. If both match, it goes to local.
- R4: An input or output transfer happens in a cycle where its write and its accept are both high. in_wok falls only when that input's FIFO holds DEPTH flits, so a blocked input takes exactly DEPTH flits.
- R5: After a first flit leaves an output, that output carries only flits of the same input until the last flit of that packet leaves. Packets never interleave.
- R6: Arbitration for an idle output starts at a priority pointer that is 0 after reset. The pointer moves to one past the input whose last flit leaves that output. Three inputs each sending two packets to east from pointer 0 are served in the order 1, 2, 4, 1, 2, 4.
- R7: When out_wr is high and out_wok is low, the next cycle still has out_wr high with the same out_flit.
- R8: A flit accepted at an input whose route is free is presented at its output in the next cycle. A packet then streams at one flit per cycle.
- R9: A packet of one flit, with both markers set, does not keep its output reserved. Two such packets from different inputs to one output leave in consecutive cycles.
- R10: Packets to different outputs move in the same cycles without waiting for each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_flit | input | 5x34 | Incoming flit for each port |
| in_wr | input | 5 | Write strobe from each upstream sender |
| in_wok | output | 5 | Input FIFO has room |
| out_flit | output | 5x34 | Outgoing flit for each port |
| out_wr | output | 5 | Outgoing flit is valid |
| out_wok | input | 5 | Downstream receiver accepts |

## Verification
The only register between input and output is the input FIFO. A flit accepted at a rising edge therefore shows on out_wr during the following cycle. The bench tags each input handshake and each output delivery with the count of the cycle in which it is sampled. The expected gaps are one cycle for latency, zero for concurrent packets, one for back-to-back single-flit packets and length minus one for streaming. The reset state and the hold under back-pressure are due in the cycle right after the causing edge. All values are sampled 2 ns after the falling edge, while every input is steady.

// File: rtl/mesh_xy_router.sv
module mesh_xy_router #(
  parameter int FLIT_W  = 34,
  parameter int COORD_W = 4,
  parameter int MY_X    = 2,
  parameter int MY_Y    = 2,
  parameter int DEPTH   = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [4:0][FLIT_W-1:0] in_flit,
  input  logic [4:0]             in_wr,
  output logic [4:0]             in_wok,
  output logic [4:0][FLIT_W-1:0] out_flit,
  output logic [4:0]             out_wr,
  input  logic [4:0]             out_wok
);
  // DEPTH must be a power of two: pointers wrap naturally
  localparam int NP = 5;
  localparam int PW = 3;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int BOP = FLIT_W - 1;
  localparam int EOP = FLIT_W - 2;
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);
  localparam logic [COORD_W-1:0] OWN_X = COORD_W'(MY_X);
  localparam logic [COORD_W-1:0] OWN_Y = COORD_W'(MY_Y);
  localparam logic [PW-1:0] D_LOC = 3'd0, D_N = 3'd1, D_S = 3'd2, D_E = 3'd3, D_W = 3'd4;

  logic [FLIT_W-1:0] mem [NP][DEPTH];
  logic [AW-1:0]     wp [NP];
  logic [AW-1:0]     rp [NP];
  logic [AW:0]       cnt [NP];
  logic [FLIT_W-1:0] head [NP];
  logic [PW-1:0]     dir [NP];
  logic [NP-1:0]     nonempty, push, pop;

  logic [NP-1:0]     req [NP];
  logic [NP-1:0]     gv, lock, act, fire;
  logic [PW-1:0]     gi [NP];
  logic [PW-1:0]     owner [NP];
  logic [PW-1:0]     rr [NP];
  logic [PW-1:0]     cur [NP];

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      head[i]     = mem[i][rp[i]];
      nonempty[i] = cnt[i] != '0;
      in_wok[i]   = cnt[i] != FULL;
      push[i]     = in_wr[i] & in_wok[i];
      if (head[i][COORD_W-1:0] > OWN_X)                dir[i] = D_E;
      else if (head[i][COORD_W-1:0] < OWN_X)           dir[i] = D_W;
      else if (head[i][2*COORD_W-1:COORD_W] > OWN_Y)   dir[i] = D_N;
      else if (head[i][2*COORD_W-1:COORD_W] < OWN_Y)   dir[i] = D_S;
      else                                             dir[i] = D_LOC;
    end
  end

  always_comb begin
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        req[o][i] = nonempty[i] & head[i][BOP] & (dir[i] == PW'(o));
  end

  always_comb begin
    for (int o = 0; o < NP; o++) begin
      gv[o] = 1'b0;
      gi[o] = '0;
      for (int k = 0; k < NP; k++) begin
        int j;
        j = int'(rr[o]) + k;
        if (j >= NP) j = j - NP;
        if (!gv[o] && req[o][j]) begin
          gv[o] = 1'b1;
          gi[o] = PW'(j);
        end
      end
      cur[o]      = lock[o] ? owner[o] : gi[o];
      act[o]      = lock[o] | gv[o];
      out_wr[o]   = act[o] & nonempty[cur[o]];
      out_flit[o] = head[cur[o]];
      fire[o]     = out_wr[o] & out_wok[o];
    end
  end

  always_comb begin
    pop = '0;
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NP; i++)
        if (fire[o] && cur[o] == PW'(i)) pop[i] = 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int o = 0; o < NP; o++) begin
      if (rst) begin
        lock[o]  <= 1'b0;
        owner[o] <= '0;
        rr[o]    <= '0;
      end else if (fire[o] && out_flit[o][EOP]) begin
        lock[o] <= 1'b0;
        rr[o]   <= (cur[o] == PW'(NP-1)) ? '0 : cur[o] + PW'(1);
      end else if (out_wr[o] && !lock[o]) begin
        lock[o]  <= 1'b1;
        owner[o] <= gi[o];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NP; i++) begin
      if (rst) begin
        wp[i]  <= '0;
        rp[i]  <= '0;
        cnt[i] <= '0;
      end else begin
        if (push[i]) begin
          mem[i][wp[i]] <= in_flit[i];
          wp[i]         <= wp[i] + AW'(1);
        end
        if (pop[i]) rp[i] <= rp[i] + AW'(1);
        case ({push[i], pop[i]})
          2'b10:   cnt[i] <= cnt[i] + (AW+1)'(1);
          2'b01:   cnt[i] <= cnt[i] - (AW+1)'(1);
          default: cnt[i] <= cnt[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/mesh_xy_router_chk.sv
module mesh_xy_router_chk #(
  parameter int FLIT_W  = 34,
  parameter int COORD_W = 4,
  parameter int MY_X    = 2,
  parameter int MY_Y    = 2,
  parameter int DEPTH   = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic [4:0][FLIT_W-1:0] in_flit,
  input logic [4:0]             in_wr,
  input logic [4:0]             in_wok,
  input logic [4:0][FLIT_W-1:0] out_flit,
  input logic [4:0]             out_wr,
  input logic [4:0]             out_wok
);
  localparam int BOP = FLIT_W - 1;
  localparam int EOP = FLIT_W - 2;

  function automatic int port_for(input logic [FLIT_W-1:0] f);
    int x, y;
    x = int'(f[COORD_W-1:0]);
    y = int'(f[2*COORD_W-1:COORD_W]);
    if (x > MY_X) return 3;
    if (x < MY_X) return 4;
    if (y > MY_Y) return 1;
    if (y < MY_Y) return 2;
    return 0;
  endfunction

  logic [4:0] in_pkt;
  always_ff @(posedge clk) begin
    for (int o = 0; o < 5; o++) begin
      if (rst) in_pkt[o] <= 1'b0;
      else if (out_wr[o] && out_wok[o]) in_pkt[o] <= !out_flit[o][EOP];
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (out_wr == 5'b0 && in_wok == 5'b11111));

  for (genvar o = 0; o < 5; o++) begin : g_port
    p_route_r3: assert property (@(posedge clk) disable iff (rst)
      (out_wr[o] && out_flit[o][BOP]) |-> port_for(out_flit[o]) == o);
    p_no_interleave_r5: assert property (@(posedge clk) disable iff (rst)
      (out_wr[o] && in_pkt[o]) |-> !out_flit[o][BOP]);
    p_head_first_r5: assert property (@(posedge clk) disable iff (rst)
      (out_wr[o] && !in_pkt[o]) |-> out_flit[o][BOP]);
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (out_wr[o] && !out_wok[o]) |=> (out_wr[o] && $stable(out_flit[o])));
  end
endmodule

bind mesh_xy_router mesh_xy_router_chk #(
  .FLIT_W(FLIT_W), .COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y), .DEPTH(DEPTH)
) chk_i (
  .clk(clk), .rst(rst), .in_flit(in_flit), .in_wr(in_wr), .in_wok(in_wok),
  .out_flit(out_flit), .out_wr(out_wr), .out_wok(out_wok)
);

// File: tb/mesh_xy_router_tb_top.sv
module mesh_xy_router_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0][33:0] in_flit;
  logic [4:0]       in_wr;
  logic [4:0]       in_wok;
  logic [4:0][33:0] out_flit;
  logic [4:0]       out_wr;
  logic [4:0]       out_wok;

  always #4 clk = ~clk;

  mesh_xy_router #(.MY_X(2), .MY_Y(2), .DEPTH(4)) dut_i (
    .clk(clk), .rst(rst), .in_flit(in_flit), .in_wr(in_wr), .in_wok(in_wok),
    .out_flit(out_flit), .out_wr(out_wr), .out_wok(out_wok)
  );

  logic [33:0] drv_q [5][$];
  logic [33:0] exp_q [25][$];
  int order_q [$];
  int errors = 0, checks = 0, cyc = 0;
  logic [4:0] fired = '0;
  int bop_in_cyc [5];
  int bop_out_cyc [5];
  int eop_out_cyc [5];
  int arr_cyc [5];
  int cur_src [5];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_port(input int dx, input int dy);
    if (dx > 2) return 3;
    if (dx < 2) return 4;
    if (dy > 2) return 1;
    if (dy < 2) return 2;
    return 0;
  endfunction

  function automatic int pending();
    int n = 0;
    for (int i = 0; i < 5; i++) n += drv_q[i].size();
    for (int i = 0; i < 25; i++) n += exp_q[i].size();
    return n;
  endfunction

  task automatic take(input int o, input logic [33:0] f);
    int s;
    s = int'(f[31:28]);
    if (exp_q[s*5+o].size() == 0) begin
      chk(0, "R3", $sformatf("unexpected flit from input %0d at port", s), o, -1);
      return;
    end
    chk(f == exp_q[s*5+o][0], "R2", "flit contents low word", int'(f[31:0]), int'(exp_q[s*5+o][0][31:0]));
    void'(exp_q[s*5+o].pop_front());
    if (f[33]) begin
      chk(cur_src[o] == -1, "R5", "new packet inside open packet, open source", cur_src[o], -1);
      bop_out_cyc[o] = cyc;
      arr_cyc[s] = cyc;
      if (o == 3) order_q.push_back(s);
      cur_src[o] = f[32] ? -1 : s;
    end else begin
      chk(cur_src[o] == s, "R5", "body flit source", s, cur_src[o]);
      if (f[32]) cur_src[o] = -1;
    end
    if (f[32]) eop_out_cyc[o] = cyc;
  endtask

  initial begin
    in_wr = '0; in_flit = '0; out_wok = '1;
    for (int i = 0; i < 5; i++) cur_src[i] = -1;
  end

  always begin
    @(negedge clk);
    cyc++;
    for (int i = 0; i < 5; i++) if (fired[i]) void'(drv_q[i].pop_front());
    for (int i = 0; i < 5; i++) begin
      if (drv_q[i].size() > 0) begin
        in_flit[i] = drv_q[i][0];
        in_wr[i] = 1'b1;
      end else begin
        in_flit[i] = '0;
        in_wr[i] = 1'b0;
      end
    end
    #2;
    for (int i = 0; i < 5; i++) begin
      fired[i] = in_wr[i] & in_wok[i] & !rst;
      if (fired[i] && in_flit[i][33]) bop_in_cyc[i] = cyc;
    end
    if (!rst)
      for (int o = 0; o < 5; o++) if (out_wr[o] && out_wok[o]) take(o, out_flit[o]);
  end

  task automatic send(input int src, input int dx, input int dy, input int len, input int seq);
    int o;
    o = exp_port(dx, dy);
    for (int k = 0; k < len; k++) begin
      logic [33:0] f;
      f = '0;
      f[33] = (k == 0);
      f[32] = (k == len - 1);
      f[31:28] = 4'(src);
      f[27:20] = 8'(seq);
      f[19:12] = 8'(k);
      if (k == 0) begin
        f[7:4] = 4'(dy);
        f[3:0] = 4'(dx);
        f[11:8] = 4'(seq * 3);
      end else begin
        f[11:0] = 12'(k * 397 + seq * 51);
      end
      drv_q[src].push_back(f);
      exp_q[src*5+o].push_back(f);
    end
  endtask

  task automatic wait_idle(input string req);
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      #3;
      if (pending() == 0) break;
    end
    chk(pending() == 0, req, "flits still undelivered", pending(), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    #3;
    chk(out_wr == 5'b0, "R1", "out_wr after reset", int'(out_wr), 0);
    chk(in_wok == 5'b11111, "R1", "in_wok after reset", int'(in_wok), 31);
  endtask

  task automatic t_routes();
    send(0, 3, 2, 3, 1);
    send(0, 1, 2, 3, 2);
    send(0, 2, 3, 2, 3);
    send(0, 2, 0, 3, 4);
    send(0, 2, 2, 2, 5);
    send(0, 7, 0, 2, 6);
    send(0, 0, 9, 2, 7);
    send(1, 2, 1, 3, 8);
    send(2, 2, 15, 2, 9);
    wait_idle("R3");
  endtask

  task automatic t_latency();
    send(4, 2, 2, 4, 10);
    wait_idle("R8");
    chk(bop_out_cyc[0] - bop_in_cyc[4] == 1, "R8", "input to output latency", bop_out_cyc[0] - bop_in_cyc[4], 1);
    chk(eop_out_cyc[0] - bop_out_cyc[0] == 3, "R8", "cycles for four-flit stream", eop_out_cyc[0] - bop_out_cyc[0], 3);
  endtask

  task automatic t_concurrent();
    send(4, 5, 2, 3, 11);
    send(3, 0, 4, 3, 12);
    wait_idle("R10");
    chk(bop_out_cyc[3] == bop_out_cyc[4], "R10", "east vs west start cycle", bop_out_cyc[3], bop_out_cyc[4]);
  endtask

  task automatic t_rr();
    int want [6] = '{1, 2, 4, 1, 2, 4};
    order_q.delete();
    for (int p = 0; p < 2; p++) begin
      send(1, 3, 2, 2, 20 + p);
      send(2, 3, 2, 2, 22 + p);
      send(4, 3, 2, 2, 24 + p);
    end
    wait_idle("R6");
    chk(order_q.size() == 6, "R6", "packets at east", order_q.size(), 6);
    for (int k = 0; k < 6 && k < order_q.size(); k++)
      chk(order_q[k] == want[k], "R6", $sformatf("grant %0d source", k), order_q[k], want[k]);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_wok[3] = 1'b0;
    send(0, 4, 1, 6, 30);
    repeat (10) @(negedge clk);
    #3;
    chk(in_wok[0] == 1'b0, "R4", "in_wok with full FIFO", int'(in_wok[0]), 0);
    chk(drv_q[0].size() == 2, "R4", "flits not yet accepted", drv_q[0].size(), 2);
    chk(out_wr[3] == 1'b1, "R7", "out_wr held while blocked", int'(out_wr[3]), 1);
    chk(exp_q[3].size() == 6, "R7", "flits delivered while blocked", 6 - exp_q[3].size(), 0);
    @(negedge clk);
    out_wok[3] = 1'b1;
    wait_idle("R7");
  endtask

  task automatic t_single();
    order_q.delete();
    send(1, 6, 6, 1, 40);
    send(2, 6, 6, 1, 41);
    wait_idle("R9");
    chk(order_q.size() == 2, "R9", "single-flit packets at east", order_q.size(), 2);
    chk(arr_cyc[2] - arr_cyc[1] == 1, "R9", "gap between single-flit packets", arr_cyc[2] - arr_cyc[1], 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_routes();
    t_latency();
    t_concurrent();
    t_rr();
    t_backpressure();
    t_single();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule